// File: doc/BRIEF.md
# Dual-Channel Offset and Gain Corrector

This block sits after a pair of synchronously sampled converters. Both channels present one signed 24-bit sample together. On each sample the block can add a per-channel signed offset word and then scale the sum by a per-channel fractional gain. It clamps the result to the 24-bit signed range, so it never wraps. A register port loads the four correction words and one control word. The control word holds the two shared stage enables and a per-channel output width select.

The offset stage is a plain adder and puts no register in the path. The whole correction runs in the cycle in which the sample arrives, and the result is registered once. This gives a fixed one-cycle latency whatever the enables are set to. When a channel runs in short mode it returns the top 16 bits of its corrected value.

Top module: `dual_cal_corrector`

## Requirements
- R1: After reset `res_valid_o` is 0 and both result ports are 0. Both stages are disabled and both channels are in 24-bit mode, so a sample passes through unchanged.
- R2: Register addresses are: 0 = offset ch0, 1 = gain ch0, 2 = offset ch1, 3 = gain ch1, and 4 = control. A write to 5, 6 or 7 changes nothing. A write applies to samples presented in later cycles.
- R3: The control word has these bits: bit0 = offset enable, bit1 = gain enable, bit2 = ch0 full width, bit3 = ch1 full width (1 = 24-bit). With only the offset stage on, the result is sat(raw + offset), where the offset is signed two's complement in units of one data LSB.
- R4: `res_valid_o` and the results appear exactly one clock after `smp_valid_i` is sampled high. No valid appears otherwise, and the latency does not depend on the enables.
- R5: With the gain stage on, the result is sat(floor(s * (2^23 + g) / 2^23)). Here g is the signed gain word with an LSB worth 2^-23, and s is the output of the offset stage.
- R6: The offset is applied before the gain. The offset sum is itself saturated before scaling.
- R7: A result above 0x7FFFFF becomes 0x7FFFFF. A result below 0x800000 (signed) becomes 0x800000.
- R8: Clearing an enable bypasses that stage but keeps its stored word. Setting the enable again reapplies the same word.
- R9: A channel in 16-bit mode outputs the corrected value's bits [23:8] on bits [15:0], with bits [23:16] zero. The other channel is unaffected.
- R10: While `smp_valid_i` is low the result ports hold their last values.
- R11: Each channel uses only its own offset and gain words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 24 | Register write data |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_ch0_i | input | 24 | Raw signed sample, channel 0 |
| smp_ch1_i | input | 24 | Raw signed sample, channel 1 |
| res_valid_o | output | 1 | Result valid, one cycle after the sample |
| res_ch0_o | output | 24 | Corrected result, channel 0 |
| res_ch1_o | output | 24 | Corrected result, channel 1 |

## Verification
The correction words and the control word are stored state. A bad stored value shows on the very next valid sample as a wrong result on one or both channels. A lost word shows only once its stage is enabled again, so the bench disables a stage, re-enables it and compares again. Address decode faults and swapped channel words show as a cross-channel mismatch on the first sample after the write. Saturation and order-of-operation faults are only visible at the rails and with both stages on, so those patterns are driven on purpose.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int CH_COUNT     = 2;
  localparam int CTRL_ADDR    = 2 * CH_COUNT;
  localparam int REG_ADDR_W   = $clog2(CTRL_ADDR + 1);
  localparam int CTRL_OFF_BIT = 0;
  localparam int CTRL_GN_BIT  = 1;
  localparam int CTRL_WID_LSB = 2;
endpackage

// File: rtl/cal_regfile.sv
module cal_regfile
  import corr_pkg::*;
#(
  parameter int DW   = 24,
  parameter int N_CH = CH_COUNT,
  parameter int AW   = REG_ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [N_CH-1:0][DW-1:0]    off_word_o,
  output logic [N_CH-1:0][DW-1:0]    gain_word_o,
  output logic                       off_en_o,
  output logic                       gain_en_o,
  output logic [N_CH-1:0]            full_w_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_word_o  <= '0;
      gain_word_o <= '0;
      off_en_o    <= 1'b0;
      gain_en_o   <= 1'b0;
      full_w_o    <= '1;
    end else if (we_i) begin
      for (int c = 0; c < N_CH; c++) begin
        if (addr_i == AW'(2 * c))     off_word_o[c]  <= wdata_i;
        if (addr_i == AW'(2 * c + 1)) gain_word_o[c] <= wdata_i;
      end
      if (addr_i == AW'(CTRL_ADDR)) begin
        off_en_o  <= wdata_i[CTRL_OFF_BIT];
        gain_en_o <= wdata_i[CTRL_GN_BIT];
        full_w_o  <= wdata_i[CTRL_WID_LSB +: N_CH];
      end
    end
  end
endmodule

// File: rtl/chan_corrector.sv
module chan_corrector #(
  parameter int DW = 24,
  parameter int SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] raw_i,
  input  logic [DW-1:0] off_word_i,
  input  logic [DW-1:0] gain_word_i,
  input  logic          off_en_i,
  input  logic          gain_en_i,
  input  logic          full_w_i,
  output logic [DW-1:0] res_o
);
  localparam int PW = 2 * DW + 1;
  localparam logic [DW-1:0] POS_RAIL = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_RAIL = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0]   sum_w;
  logic [DW-1:0] sum_sat;
  logic [DW:0]   mult_k;
  logic signed [PW-1:0] prod, scaled;
  logic [DW-1:0] gain_sat, corr, shaped;

  // offset stage: purely combinational, no added latency
  always_comb begin
    sum_w = {raw_i[DW-1], raw_i};
    if (off_en_i) sum_w = sum_w + {off_word_i[DW-1], off_word_i};
    if (sum_w[DW] != sum_w[DW-1]) sum_sat = sum_w[DW] ? NEG_RAIL : POS_RAIL;
    else                          sum_sat = sum_w[DW-1:0];
  end

  // gain stage: multiplier is 1.0 + word * 2^-(DW-1)
  always_comb begin
    mult_k = {2'b01, {(DW-1){1'b0}}} + {gain_word_i[DW-1], gain_word_i};
    prod   = $signed({{(DW+1){sum_sat[DW-1]}}, sum_sat})
           * $signed({{DW{mult_k[DW]}}, mult_k});
    scaled = prod >>> (DW - 1);
    if (scaled[PW-1:DW-1] != {(PW-DW+1){scaled[PW-1]}})
      gain_sat = scaled[PW-1] ? NEG_RAIL : POS_RAIL;
    else
      gain_sat = scaled[DW-1:0];
    corr = gain_en_i ? gain_sat : sum_sat;
  end

  assign shaped = full_w_i ? corr : {{(DW-SW){1'b0}}, corr[DW-1 -: SW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_o <= '0;
    else if (valid_i) res_o <= shaped;
  end
endmodule

// File: rtl/dual_cal_corrector.sv
module dual_cal_corrector
  import corr_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  input  logic                  smp_valid_i,
  input  logic [DATA_W-1:0]     smp_ch0_i,
  input  logic [DATA_W-1:0]     smp_ch1_i,
  output logic                  res_valid_o,
  output logic [DATA_W-1:0]     res_ch0_o,
  output logic [DATA_W-1:0]     res_ch1_o
);
  logic [CH_COUNT-1:0][DATA_W-1:0] off_word, gain_word, raw, res;
  logic                            off_en, gain_en;
  logic [CH_COUNT-1:0]             full_w;

  cal_regfile #(.DW(DATA_W), .N_CH(CH_COUNT), .AW(REG_ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .off_word_o  (off_word),
    .gain_word_o (gain_word),
    .off_en_o    (off_en),
    .gain_en_o   (gain_en),
    .full_w_o    (full_w)
  );

  assign raw[0] = smp_ch0_i;
  assign raw[1] = smp_ch1_i;

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    chan_corrector #(.DW(DATA_W), .SW(SHORT_W)) u_corr (
      .clk_i, .rst_ni,
      .valid_i     (smp_valid_i),
      .raw_i       (raw[c]),
      .off_word_i  (off_word[c]),
      .gain_word_i (gain_word[c]),
      .off_en_i    (off_en),
      .gain_en_i   (gain_en),
      .full_w_i    (full_w[c]),
      .res_o       (res[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_valid_o <= 1'b0;
    else         res_valid_o <= smp_valid_i;
  end

  assign res_ch0_o = res[0];
  assign res_ch1_o = res[1];
endmodule

// File: rtl/dual_cal_corrector_chk.sv
module dual_cal_corrector_chk #(
  parameter int DW = 24,
  parameter int SW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_valid_i,
  input logic [DW-1:0] smp_ch0_i,
  input logic [DW-1:0] smp_ch1_i,
  input logic          res_valid_o,
  input logic [DW-1:0] res_ch0_o,
  input logic [DW-1:0] res_ch1_o,
  input logic          off_en,
  input logic          gain_en,
  input logic [1:0]    full_w,
  input logic [DW-1:0] off_word0,
  input logic [DW-1:0] gain_word1
);
  localparam logic [DW-1:0] POS_RAIL = {1'b0, {(DW-1){1'b1}}};

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> res_valid_o); // R4
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !res_valid_o); // R4
  AST_HOLD_CH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(res_ch0_o)); // R10
  AST_HOLD_CH1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(res_ch1_o)); // R10
  AST_BYPASS_CH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !off_en && !gain_en && full_w[0]) |=> res_ch0_o == $past(smp_ch0_i)); // R8
  AST_UNITY_GAIN_CH1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !off_en && gain_en && gain_word1 == '0 && full_w[1])
      |=> res_ch1_o == $past(smp_ch1_i)); // R5
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !full_w[0]) |=> res_ch0_o[DW-1:SW] == '0); // R9
  AST_POS_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && off_en && !gain_en && full_w[0] && smp_ch0_i == POS_RAIL && !off_word0[DW-1])
      |=> res_ch0_o == POS_RAIL); // R7
endmodule

bind dual_cal_corrector dual_cal_corrector_chk #(.DW(DATA_W), .SW(SHORT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .smp_ch0_i   (smp_ch0_i),
  .smp_ch1_i   (smp_ch1_i),
  .res_valid_o (res_valid_o),
  .res_ch0_o   (res_ch0_o),
  .res_ch1_o   (res_ch1_o),
  .off_en      (off_en),
  .gain_en     (gain_en),
  .full_w      (full_w),
  .off_word0   (off_word[0]),
  .gain_word1  (gain_word[1])
);

// File: tb/tb_dual_cal_corrector.sv
module tb_dual_cal_corrector;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [23:0] reg_wdata_i = '0;
  logic        smp_valid_i = 1'b0;
  logic [23:0] smp_ch0_i = '0, smp_ch1_i = '0;
  logic        res_valid_o;
  logic [23:0] res_ch0_o, res_ch1_o;

  always #10 clk = ~clk;

  dual_cal_corrector dut (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .smp_valid_i, .smp_ch0_i, .smp_ch1_i, .res_valid_o, .res_ch0_o, .res_ch1_o
  );

  typedef struct { logic [23:0] e0; logic [23:0] e1; string tag; } exp_t;
  exp_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [23:0] sh_off[2], sh_gain[2];
  bit sh_oen = 0, sh_gen = 0;
  bit [1:0] sh_full = 2'b11;

  function automatic longint clamp(longint v);
    if (v > 64'sd8388607)  return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic logic [23:0] model(logic [23:0] x, int c);
    longint s;
    logic [23:0] r;
    s = longint'($signed(x));
    if (sh_oen) s = clamp(s + longint'($signed(sh_off[c])));
    if (sh_gen) s = clamp((s * (64'sd8388608 + longint'($signed(sh_gain[c])))) >>> 23);
    r = s[23:0];
    return sh_full[c] ? r : {8'h00, r[23:8]};
  endfunction

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [23:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    case (a)
      3'd0: sh_off[0] = d;
      3'd1: sh_gain[0] = d;
      3'd2: sh_off[1] = d;
      3'd3: sh_gain[1] = d;
      3'd4: begin sh_oen = d[0]; sh_gen = d[1]; sh_full = d[3:2]; end
      default: ;
    endcase
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic send(logic [23:0] x0, logic [23:0] x1, string tag);
    @(negedge clk);
    smp_ch0_i = x0; smp_ch1_i = x1; smp_valid_i = 1'b1;
    sbq.push_back('{model(x0, 0), model(x1, 1), tag});
    @(negedge clk);
    smp_valid_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && res_valid_o) begin
      if (sbq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R4 unexpected valid act=1 exp=0");
      end else begin
        exp_t it;
        it = sbq.pop_front();
        chk({it.tag, " ch0"}, res_ch0_o, it.e0);
        chk({it.tag, " ch1"}, res_ch1_o, it.e1);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [23:0] h0, h1;
    sh_off = '{24'h0, 24'h0}; sh_gain = '{24'h0, 24'h0};
    repeat (3) @(negedge clk);
    chk("R1 valid", {23'h0, res_valid_o}, 24'h0);
    chk("R1 ch0", res_ch0_o, 24'h0);
    chk("R1 ch1", res_ch1_o, 24'h0);
    rst_ni = 1'b1;
    send(24'h123456, 24'h800001, "R1 default bypass");

    // offset only
    wr(3'd0, 24'd1000); wr(3'd2, 24'hFFFFFB); wr(3'd4, 24'hD);
    send(24'h000010, 24'hFFFF00, "R3 offset");
    send(24'hFFFFFF, 24'h000004, "R3 offset sign");
    // rails
    wr(3'd0, 24'h7FFFFF); wr(3'd2, 24'h800000);
    send(24'h000001, 24'hFFFFFF, "R7 rail");
    send(24'h000000, 24'h000000, "R7 max words");
    // gain only
    wr(3'd4, 24'hE); wr(3'd1, 24'h7FFFFF); wr(3'd3, 24'hC00000);
    send(24'h400000, 24'hFFFFFD, "R5 gain floor");
    send(24'h400001, 24'h7FFFFF, "R7 gain sat");
    wr(3'd1, 24'h800000);
    send(24'h7FFFFF, 24'h800000, "R5 gain min");
    // both, order
    wr(3'd0, 24'd100); wr(3'd1, 24'h400000); wr(3'd4, 24'hF);
    send(24'd200, 24'h000000, "R6 order");
    send(24'd200, 24'd5, "R11 independent");
    // disable keeps words
    wr(3'd4, 24'hC);
    send(24'd200, 24'd5, "R8 bypass");
    wr(3'd4, 24'hF);
    send(24'd200, 24'd5, "R8 reenable");
    // ignored addresses
    wr(3'd5, 24'hFFFFFF); wr(3'd6, 24'h123456); wr(3'd7, 24'h0);
    send(24'd200, 24'd5, "R2 unused addr");
    // 16-bit modes
    wr(3'd4, 24'h7);
    send(24'd200, 24'h00ABCD, "R9 ch1 short");
    wr(3'd4, 24'h8);
    send(24'h123456, 24'hABCDEF, "R9 ch0 short");
    // hold
    h0 = model(24'h123456, 0); h1 = model(24'hABCDEF, 1);
    repeat (3) @(negedge clk);
    chk("R10 hold ch0", res_ch0_o, h0);
    chk("R10 hold ch1", res_ch1_o, h1);
    // latency with both stages on
    wr(3'd4, 24'hF);
    send(24'h7FFFF0, 24'h800010, "R4 latency");
    repeat (4) @(negedge clk);
    chk("R4 pending", 24'(sbq.size()), 24'h0);
    finish_run();
  end
endmodule